// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block is a serial-bus master that fetches one 10-bit sample from an external converter. A single-cycle `start` request opens a read. The block lowers chip select, generates sixteen serial clock pulses as two back-to-back 8-bit frames, and sends the command byte most-significant-bit first during the first frame. During the second frame it sends zeros. At the same time it shifts in the converter's data line.

The command byte places its start bit so that the converter's two top result bits land in the last two bit times of the first frame. The remaining eight result bits fill the second frame. The block keeps only the last ten bits received, which yields a right-justified code: the upper six bits of the first frame are discarded.

A signed offset, latched when the read begins, is subtracted from the raw code. The difference is clamped to the range 0..1023. The corrected value is written to `result` and announced by a one-cycle `done` strobe.

Top module: `serial_adc_reader`

## Requirements
- R1: While `rst` is high, and after it is released, `cs_n` is 1, `sclk` is 0, `mosi` is 0, `done` is 0 and `result` is 0 until a read completes.
- R2: A `start` seen while idle drives `cs_n` low at the next clock edge. `cs_n` stays low until the edge on which the 16th `sclk` pulse falls, and rises exactly there.
- R3: `sclk` is low whenever `cs_n` is high. With HALF_DIV = H, its first rising edge comes H system clocks after `cs_n` falls, and it toggles every H clocks. It gives exactly 16 rising edges per read.
- R4: `mosi` carries the 16-bit stream {cmd_byte, 8'h00} MSB first. The first bit appears when `cs_n` falls, and `mosi` changes only when `sclk` falls. It is 0 when idle.
- R5: `miso` is sampled on each `sclk` rising edge. The raw code takes bits 9:8 from bits 1:0 of the first received byte, and bits 7:0 from the second byte. Bits 7:2 of the first byte have no effect on the code.
- R6: `offset` is an 11-bit two's-complement value sampled at the accepting `start`. `result` equals the raw code minus that offset.
- R7: A difference below 0 gives a `result` of 0.
- R8: A difference above 1023 gives a `result` of 1023.
- R9: A `start` arriving while a read is in progress is ignored: neither the result nor the command stream changes, and no extra read follows.
- R10: `done` is high for exactly one clock per read, on the edge where `result` updates and `cs_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin one read |
| cmd_byte | input | 8 | Command byte sent in the first frame |
| offset | input | 11 | Signed correction subtracted from the raw code |
| miso | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the converter |
| result | output | 10 | Offset-corrected, saturated code |
| done | output | 1 | One-cycle strobe when `result` updates |

## Verification
The hardest situation to reach from the ports is a start request landing in the middle of a read. In that case the block must keep both the outgoing command stream and the captured bits untouched. The stimulus pulses `start` with a different command byte partway through a frame. It then checks that `mosi`, `result` and `cs_n` follow only the first request, and that no second read begins afterwards.

Both clamp limits are reached by pairing chosen converter words with large positive and large negative offsets. The converter words carry garbage in the six discarded bits, so a wrong bit position shows up in `result`.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    localparam int FRAME_W   = 8;
    localparam int N_FRAMES  = 2;
    localparam int RES_W     = 10;
    localparam int XFER_W    = FRAME_W * N_FRAMES;
    localparam int BITCNT_W  = $clog2(XFER_W + 1);
    localparam int OFS_W     = RES_W + 1;
    localparam int DIFF_W    = RES_W + 2;

    typedef logic [FRAME_W-1:0]        frame_t;
    typedef logic [RES_W-1:0]          code_t;
    typedef logic signed [OFS_W-1:0]   ofs_t;

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_XFER = 1'b1
    } rd_state_e;

    typedef struct packed {
        rd_state_e state;
        logic      cs_n;
        ofs_t      ofs;
    } rd_ctrl_t;

    // Subtract a signed offset and clamp to the code range.
    function automatic code_t sat_sub(code_t raw, ofs_t ofs);
        logic signed [DIFF_W-1:0] d;
        d = $signed({2'b00, raw}) - $signed({{(DIFF_W-OFS_W){ofs[OFS_W-1]}}, ofs});
        if (d[DIFF_W-1])
            return '0;
        else if (d[RES_W])
            return '1;
        else
            return d[RES_W-1:0];
    endfunction

endpackage

// File: rtl/adc_rd_sclk_gen.sv
module adc_rd_sclk_gen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic sclk,
    output logic rise_evt,
    output logic fall_evt
);
    localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [DW-1:0] cnt_q;
    logic          wrap;

    assign wrap     = (cnt_q == DW'(HALF_DIV - 1));
    assign rise_evt = run && wrap && !sclk;
    assign fall_evt = run && wrap && sclk;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
            sclk  <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            sclk  <= ~sclk;
        end else begin
            cnt_q <= cnt_q + DW'(1);
        end
    end
endmodule

// File: rtl/adc_rd_shifter.sv
module adc_rd_shifter
    import adc_rd_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  frame_t cmd,
    input  logic   rise_evt,
    input  logic   fall_evt,
    input  logic   miso,
    output logic   mosi,
    output code_t  raw_code,
    output logic   last_fall
);
    logic [XFER_W-1:0]   tx_q;
    logic [XFER_W-1:0]   tx_init;
    code_t               rx_q;
    logic [BITCNT_W-1:0] cnt_q;

    // Frame 0 carries the command, every later frame is zero.
    for (genvar f = 0; f < N_FRAMES; f++) begin : g_frame
        if (f == 0) begin : g_cmd
            assign tx_init[XFER_W-1 -: FRAME_W] = cmd;
        end else begin : g_zero
            assign tx_init[XFER_W-1-f*FRAME_W -: FRAME_W] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q  <= '0;
            rx_q  <= '0;
            cnt_q <= '0;
        end else if (load) begin
            tx_q  <= tx_init;
            cnt_q <= '0;
        end else begin
            if (rise_evt) begin
                // Only the last RES_W bits are kept: leading bits fall off.
                rx_q  <= {rx_q[RES_W-2:0], miso};
                cnt_q <= cnt_q + BITCNT_W'(1);
            end
            if (fall_evt) begin
                tx_q <= {tx_q[XFER_W-2:0], 1'b0};
            end
        end
    end

    assign mosi      = tx_q[XFER_W-1];
    assign raw_code  = rx_q;
    assign last_fall = fall_evt && (cnt_q == BITCNT_W'(XFER_W));
endmodule

// File: rtl/adc_rd_correct.sv
module adc_rd_correct
    import adc_rd_pkg::*;
(
    input  code_t raw_code,
    input  ofs_t  ofs,
    output code_t corrected
);
    always_comb begin
        corrected = sat_sub(raw_code, ofs);
    end
endmodule

// File: rtl/serial_adc_reader.sv
module serial_adc_reader
    import adc_rd_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [7:0]        cmd_byte,
    input  logic signed [10:0] offset,
    input  logic              miso,
    output logic              cs_n,
    output logic              sclk,
    output logic              mosi,
    output logic [9:0]        result,
    output logic              done
);
    rd_ctrl_t ctrl_q;
    code_t    result_q;
    logic     done_q;
    logic     run;
    logic     accept;
    logic     rise_evt;
    logic     fall_evt;
    logic     last_fall;
    code_t    raw_code;
    code_t    corrected;

    assign run    = (ctrl_q.state == RD_XFER);
    assign accept = (ctrl_q.state == RD_IDLE) && start;

    adc_rd_sclk_gen #(.HALF_DIV(HALF_DIV)) u_sclk (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .sclk     (sclk),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    adc_rd_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .cmd       (cmd_byte),
        .rise_evt  (rise_evt),
        .fall_evt  (fall_evt),
        .miso      (miso),
        .mosi      (mosi),
        .raw_code  (raw_code),
        .last_fall (last_fall)
    );

    adc_rd_correct u_corr (
        .raw_code  (raw_code),
        .ofs       (ctrl_q.ofs),
        .corrected (corrected)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q.state <= RD_IDLE;
            ctrl_q.cs_n  <= 1'b1;
            ctrl_q.ofs   <= '0;
            result_q     <= '0;
            done_q       <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (ctrl_q.state)
                RD_IDLE: begin
                    if (start) begin
                        ctrl_q.state <= RD_XFER;
                        ctrl_q.cs_n  <= 1'b0;
                        ctrl_q.ofs   <= offset;
                    end
                end
                RD_XFER: begin
                    if (last_fall) begin
                        ctrl_q.state <= RD_IDLE;
                        ctrl_q.cs_n  <= 1'b1;
                        result_q     <= corrected;
                        done_q       <= 1'b1;
                    end
                end
                default: ctrl_q.state <= RD_IDLE;
            endcase
        end
    end

    assign cs_n   = ctrl_q.cs_n;
    assign result = result_q;
    assign done   = done_q;
endmodule

// File: rtl/serial_adc_reader_chk.sv
module serial_adc_reader_chk (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       sclk,
    input logic       mosi,
    input logic       done,
    input logic [9:0] result
);
    logic [5:0] rises;
    logic       sclk_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            rises  <= '0;
            sclk_d <= 1'b0;
        end else begin
            sclk_d <= sclk;
            if (cs_n)
                rises <= '0;
            else if (sclk && !sclk_d)
                rises <= rises + 6'd1;
        end
    end

    // R1: outputs idle right after reset
    a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cs_n && !sclk && !mosi && !done && result == 10'd0));

    // R3: clock stays low while deselected
    a_r3_sclk_idle_low: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);

    // R3: exactly sixteen rising edges inside a select window
    a_r3_sixteen_edges: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |-> ((rises + {5'd0, (sclk_d == 1'b0)}) == 6'd16));

    // R4: data out moves only on a falling serial clock
    a_r4_mosi_on_fall: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && $past(!cs_n) && !$fell(sclk)) |-> $stable(mosi));

    // R10: strobe lasts one cycle
    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10: strobe coincides with deselect
    a_r10_done_with_cs: assert property (@(posedge clk) disable iff (rst)
        done |-> (cs_n && !$past(cs_n)));

    // R10: result only moves with the strobe
    a_r10_result_hold: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result));
endmodule

bind serial_adc_reader serial_adc_reader_chk chk_i (
    .clk    (clk),
    .rst    (rst),
    .cs_n   (cs_n),
    .sclk   (sclk),
    .mosi   (mosi),
    .done   (done),
    .result (result)
);

// File: tb/serial_adc_reader_tb.sv
module serial_adc_reader_tb_top;
    localparam int H = 2;
    localparam int READ_CYC = 32 * H;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [7:0]        cmd_byte = 8'h00;
    logic signed [10:0] offset = '0;
    logic              miso = 1'b0;
    logic              cs_n, sclk, mosi, done;
    logic [9:0]        result;

    int n_tests = 0;
    int n_fail  = 0;
    int n_done  = 0;
    int cycles  = 0;

    // behavioural reference state
    bit        m_busy = 0;
    int        m_t = 0;
    bit        m_done = 0;
    int        m_result = 0;
    logic [15:0] m_stream = '0;
    int        m_off = 0;
    logic [15:0] sw = '0;   // converter word presented on miso

    always #4 clk = ~clk;

    serial_adc_reader #(.HALF_DIV(H)) dut_i (
        .clk(clk), .rst(rst), .start(start), .cmd_byte(cmd_byte),
        .offset(offset), .miso(miso), .cs_n(cs_n), .sclk(sclk),
        .mosi(mosi), .result(result), .done(done)
    );

    function automatic int clamp(int v);
        if (v < 0) return 0;
        if (v > 1023) return 1023;
        return v;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_busy = 0; m_t = 0; m_done = 0; m_result = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_t++;
                if (m_t == READ_CYC) begin
                    m_busy   = 0;
                    m_done   = 1;
                    m_result = clamp(int'(sw[9:0]) - m_off);
                end
            end else if (start) begin
                m_busy   = 1;
                m_t      = 0;
                m_stream = {cmd_byte, 8'h00};
                m_off    = int'(offset);
            end
        end
    end

    // converter model and per-cycle comparison
    always @(negedge clk) begin
        miso <= m_busy ? sw[15 - m_t / (2 * H)] : 1'b0;
        if (!rst) begin
            if (done) n_done++;
            chk("R2 cs_n", cs_n, m_busy ? 0 : 1);
            chk("R3 sclk", sclk, (m_busy && ((m_t / H) % 2 == 1)) ? 1 : 0);
            chk("R4 mosi", mosi, m_busy ? m_stream[15 - m_t / (2 * H)] : 0);
            chk("R10 done", done, m_done);
            chk("R5 result", result, m_result);
        end
    end

    task automatic do_read(input logic [7:0] c, input logic [15:0] w, input int ofs);
        @(negedge clk);
        sw = w; cmd_byte = c; offset = 11'(ofs); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (READ_CYC + 2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 cs_n in reset", cs_n, 1);
        chk("R1 sclk in reset", sclk, 0);
        chk("R1 mosi in reset", mosi, 0);
        chk("R1 result in reset", result, 0);
        chk("R1 done in reset", done, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R5: garbage in the discarded bits must not reach the code
        do_read(8'h06, 16'b101101_10_0101_1010, 0);
        chk("R5 right-justified code", result, 10'h25A);

        do_read(8'hC3, 16'b000000_11_1111_1111, 0);
        chk("R5 full-scale code", result, 1023);

        // R6 offset subtraction, positive and negative
        do_read(8'h5A, 16'b111111_01_0000_0000, 17);
        chk("R6 positive offset", result, 256 - 17);
        do_read(8'h81, 16'b010101_00_0110_0100, -28);
        chk("R6 negative offset", result, 100 + 28);

        // R7 lower clamp
        do_read(8'h0F, 16'b110011_00_0001_0000, 500);
        chk("R7 clamp at zero", result, 0);

        // R8 upper clamp
        do_read(8'hF0, 16'b001100_11_1111_0000, -100);
        chk("R8 clamp at full scale", result, 1023);

        // R9 start while busy is ignored
        n_done = 0;
        @(negedge clk);
        sw = 16'b111000_01_1000_0001; cmd_byte = 8'h35; offset = 11'sd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        cmd_byte = 8'hFF; offset = 11'sd300; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (READ_CYC) @(negedge clk);
        chk("R9 result unaffected by busy start", result, 10'h181);
        repeat (6) @(negedge clk);
        chk("R9 no extra read", cs_n, 1);
        chk("R10 one done per read", n_done, 1);

        // R10 back-to-back reads with start held high
        n_done = 0;
        @(negedge clk);
        sw = 16'b000000_10_1010_1010; cmd_byte = 8'h3C; offset = 11'sd2; start = 1'b1;
        repeat (2 * (READ_CYC + 1) - 1) @(negedge clk);
        start = 1'b0;
        repeat (READ_CYC + 4) @(negedge clk);
        chk("R10 two reads with held start", n_done, 2);
        chk("R6 held-start result", result, 10'h2AA - 2);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule